// File: doc/BRIEF.md
# Adaptive Delta Modulation Encoder

This block turns a stream of signed, already digitised samples into a one-bit-per-sample code. It holds a running estimate of the input. For each accepted sample it decides whether the sample lies at or above that estimate, or below it. It emits that decision as one bit, then moves the estimate toward the sample by the current step size.

The step size is not fixed. It doubles while the output bits keep repeating, which is how the block follows a steep slope. It halves when the bits flip, which keeps the estimate from jittering around a flat input. The step always stays between two parameter limits. The estimate clips at the ends of the signed range instead of wrapping around. The whole decision and update loop closes within one clock period. A sample is taken only on cycles where the strobe is high.

The output bit and its valid flag are registered. The current estimate is brought out so that a receiver model or a monitor can follow the loop.

Top module: `adm_encoder`

## Requirements
- R1: For each accepted sample, the output bit is 1 when (sample − estimate) ≥ 0, which includes a difference of exactly zero, and 0 when the difference is negative. The difference is formed one bit wider than the data, so it never overflows.
- R2: When the bit is 1 the estimate grows by the step that was in force for that sample; when the bit is 0 it shrinks by that step. The step is adapted only after it has been used.
- R3: When the new bit equals the previously stored bit, the step doubles (a left shift by one), limited to STEP_MAX.
- R4: When the new bit differs from the previously stored bit, the step halves (a right shift by one), limited to no less than STEP_MIN.
- R5: The estimate saturates at 2^(DATA_W−1)−1 and −2^(DATA_W−1) instead of wrapping.
- R6: Synchronous active-high reset sets the estimate to 0, the step to STEP_MIN, the stored previous bit to 0, and both bit_o and bit_vld_o to 0.
- R7: On cycles where smp_vld_i is low, the estimate, the step, the stored bit and bit_o all keep their values, whatever smp_i carries. bit_vld_o is high exactly one cycle after each cycle in which smp_vld_i is high.
- R8: Results appear one clock after the sample edge: bit_o and est_o reflect the sample accepted on the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample strobe; the sample is accepted when high |
| smp_i | input | DATA_W | Signed input sample (two's complement) |
| bit_o | output | 1 | Encoded bit for the last accepted sample |
| bit_vld_o | output | 1 | High for one cycle after each accepted sample |
| est_o | output | DATA_W | Signed current estimate (two's complement) |

## Verification
The bench targets several corner cases, each chosen because a specific mistake would show up there:
- A difference of exactly zero. A design that treats zero as negative emits a 0 and moves the estimate down.
- A step that is pushed against its upper and lower clamps. A design with a missing clamp either overshoots STEP_MAX, or falls to zero and freezes the estimate.
- An estimate driven past both signed extremes. A design that wraps flips its sign and outputs a wildly wrong value.
- Gaps in the strobe while the sample input changes. A design that leaks state through a gap produces a wrong estimate on the next accepted sample.
- A reset issued mid-run. A design that fails to clear the stored bit grows its step on the second sample instead of keeping it.

// File: rtl/adm_pkg.sv
package adm_pkg;

  // Action taken on the step register after a sample is coded
  typedef enum logic [1:0] {
    STEP_KEEP   = 2'd0,
    STEP_GROW   = 2'd1,
    STEP_SHRINK = 2'd2
  } step_act_e;

  // Decide whether the step grows or shrinks from the bit pattern
  function automatic step_act_e pick_act(input logic vld, input logic cur_bit,
                                         input logic last_bit);
    if (!vld)                 return STEP_KEEP;
    if (cur_bit == last_bit)  return STEP_GROW;
    return STEP_SHRINK;
  endfunction

endpackage

// File: rtl/adm_cmp.sv
// Sign decision: sample minus estimate, formed one bit wider than the data
module adm_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] smp_i,
  input  logic [DATA_W-1:0] est_i,
  output logic              up_o
);
  logic signed [DATA_W:0] diff;

  always_comb begin
    diff = $signed({smp_i[DATA_W-1], smp_i}) - $signed({est_i[DATA_W-1], est_i});
    // A non-negative difference (zero included) codes as 1
    up_o = ~diff[DATA_W];
  end
endmodule

// File: rtl/adm_step.sv
// Step register with grow/shrink adaptation and clamping; holds the last bit
module adm_step
  import adm_pkg::*;
#(
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 1024,
  parameter int STEP_W   = $clog2(STEP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic              up_i,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W:0]   MAX_X = (STEP_W+1)'(STEP_MAX);
  localparam logic [STEP_W:0]   MIN_X = (STEP_W+1)'(STEP_MIN);
  localparam logic [STEP_W-1:0] MAX_S = STEP_W'(STEP_MAX);
  localparam logic [STEP_W-1:0] MIN_S = STEP_W'(STEP_MIN);

  logic [STEP_W-1:0] step_q, step_d;
  logic              last_q;
  logic [STEP_W:0]   dbl, half;
  step_act_e         act;

  always_comb begin
    act  = pick_act(vld_i, up_i, last_q);
    dbl  = {step_q, 1'b0};
    half = {1'b0, step_q} >> 1;
    unique case (act)
      STEP_GROW:   step_d = (dbl > MAX_X) ? MAX_S : dbl[STEP_W-1:0];
      STEP_SHRINK: step_d = (half < MIN_X) ? MIN_S : half[STEP_W-1:0];
      default:     step_d = step_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= MIN_S;
      last_q <= 1'b0;
    end else if (vld_i) begin
      step_q <= step_d;
      last_q <= up_i;
    end
  end

  assign step_o = step_q;

  // R3/R4: the step never leaves its clamp range
  assert_step_range_R3: assert property (@(posedge clk) disable iff (rst)
    (step_q >= MIN_S) && (step_q <= MAX_S));

  // R7: no strobe, no change to step or last bit
  assert_step_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> ($stable(step_q) && $stable(last_q)));

  // R3: a repeated bit never makes the step smaller
  assert_step_grow_R3: assert property (@(posedge clk) disable iff (rst)
    (vld_i && (up_i == last_q)) |=> (step_q >= $past(step_q)));

  // R4: an alternating bit never makes the step larger
  assert_step_shrink_R4: assert property (@(posedge clk) disable iff (rst)
    (vld_i && (up_i != last_q)) |=> (step_q <= $past(step_q)));
endmodule

// File: rtl/adm_acc.sv
// Estimate accumulator: adds or subtracts the step, saturating at signed limits
module adm_acc #(
  parameter int DATA_W = 16,
  parameter int STEP_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic              up_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [DATA_W-1:0] est_o
);
  localparam logic signed [DATA_W:0] HI = {2'b00, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W:0] LO = {2'b11, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0]      est_q, est_d;
  logic signed [DATA_W:0] ext_est, ext_step, sum;

  always_comb begin
    ext_est  = $signed({est_q[DATA_W-1], est_q});
    ext_step = $signed({{(DATA_W+1-STEP_W){1'b0}}, step_i});
    sum      = up_i ? (ext_est + ext_step) : (ext_est - ext_step);
    if (sum > HI)      est_d = HI[DATA_W-1:0];
    else if (sum < LO) est_d = LO[DATA_W-1:0];
    else               est_d = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        est_q <= '0;
    else if (vld_i) est_q <= est_d;
  end

  assign est_o = est_q;

  // R2: a 1 bit never lowers the estimate, a 0 bit never raises it
  assert_est_up_R2: assert property (@(posedge clk) disable iff (rst)
    (vld_i && up_i) |=> ($signed(est_q) >= $signed($past(est_q))));
  assert_est_down_R2: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !up_i) |=> ($signed(est_q) <= $signed($past(est_q))));

  // R7: the estimate holds without a strobe
  assert_est_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(est_q));
endmodule

// File: rtl/adm_encoder.sv
// Adaptive delta modulation encoder, single-cycle feedback loop
module adm_encoder #(
  parameter int DATA_W   = 16,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] smp_i,
  output logic              bit_o,
  output logic              bit_vld_o,
  output logic [DATA_W-1:0] est_o
);
  localparam int STEP_W = $clog2(STEP_MAX + 1);

  logic              up;
  logic [STEP_W-1:0] step;
  logic [DATA_W-1:0] est;

  adm_cmp #(.DATA_W(DATA_W)) cmp_i (
    .smp_i (smp_i),
    .est_i (est),
    .up_o  (up)
  );

  adm_step #(.STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_W(STEP_W)) step_i (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (smp_vld_i),
    .up_i   (up),
    .step_o (step)
  );

  adm_acc #(.DATA_W(DATA_W), .STEP_W(STEP_W)) acc_i (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (smp_vld_i),
    .up_i   (up),
    .step_i (step),
    .est_o  (est)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
    end else begin
      bit_vld_o <= smp_vld_i;
      if (smp_vld_i) bit_o <= up;
    end
  end

  assign est_o = est;

  // R1/R8: the bit reflects the sign of the previous sample against the previous estimate
  assert_bit_sign_R1: assert property (@(posedge clk) disable iff (rst)
    smp_vld_i |=> (bit_o == ($signed($past(smp_i)) >= $signed($past(est)))));

  // R7: the valid flag follows the strobe by one cycle
  assert_vld_rise_R7: assert property (@(posedge clk) disable iff (rst)
    smp_vld_i |=> bit_vld_o);
  assert_vld_fall_R7: assert property (@(posedge clk) disable iff (rst)
    !smp_vld_i |=> (!bit_vld_o && $stable(bit_o)));
endmodule

// File: tb/adm_encoder_tb.sv
`timescale 1ns/1ps
module adm_encoder_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_vld = 1'b0;
  logic [W-1:0] smp = '0;
  logic         bit_o, bit_vld;
  logic [W-1:0] est;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  adm_encoder #(.DATA_W(W), .STEP_MIN(1), .STEP_MAX(32)) dut_i (
    .clk(clk), .rst(rst), .smp_vld_i(smp_vld), .smp_i(smp),
    .bit_o(bit_o), .bit_vld_o(bit_vld), .est_o(est)
  );

  // Vectors: sample, expected bit, expected estimate after it (step 1..32, 8-bit data)
  localparam int N = 26;
  localparam int SMP [N] = '{10, 10, 10, 10, 10, 10, 0, 0, 0, 0,
                             -100, -100, -100, -100, -128, -128, -128,
                             127, 127, 127, 127, 127, 127, 127, 127, 127};
  localparam int BIT [N] = '{1, 1, 1, 1, 1, 0, 1, 0, 0, 0,
                             0, 0, 0, 0, 0, 0, 1,
                             1, 1, 1, 1, 1, 1, 1, 1, 1};
  localparam int EST [N] = '{1, 2, 4, 8, 16, 0, 8, 4, 2, -2,
                             -10, -26, -58, -90, -122, -128, -96,
                             -80, -48, -16, 16, 48, 80, 112, 127, 127};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int x);
    @(negedge clk);
    smp_vld = 1'b1;
    smp     = W'(x);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    chk("R6 est", $signed(est), 0);
    chk("R6 bit", int'(bit_o), 0);
    chk("R6 vld", int'(bit_vld), 0);
    rst = 1'b0;

    // Vector walk: R1 zero-difference, R2, R3/R4 with clamps, R5 saturation, R8 latency
    for (int i = 0; i < N; i++) begin
      put(SMP[i]);
      chk($sformatf("R1/R8 bit v%0d", i), int'(bit_o), BIT[i]);
      chk($sformatf("R2/R3/R4/R5 est v%0d", i), $signed(est), EST[i]);
      chk($sformatf("R7 vld v%0d", i), int'(bit_vld), 1);
    end

    // R7: gap with a changing sample; nothing moves, valid drops
    for (int g = 0; g < 5; g++) begin
      @(negedge clk);
      smp = W'(-50 + g);
      chk("R7 gap vld", int'(bit_vld), 0);
      chk("R7 gap est", $signed(est), 127);
      chk("R7 gap bit", int'(bit_o), 1);
    end

    // Step 32 held through the gap: 127-32=95, then R4 halves to 16, then R3 grows to 32
    put(0);
    chk("R7 step held", $signed(est), 95);
    chk("R1 bit low", int'(bit_o), 0);
    put(0);
    chk("R4 halved step", $signed(est), 79);
    put(0);
    chk("R3 grown step", $signed(est), 47);

    // R6: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 mid est", $signed(est), 0);
    chk("R6 mid bit", int'(bit_o), 0);
    chk("R6 mid vld", int'(bit_vld), 0);
    rst = 1'b0;
    // Stored bit cleared to 0: first 1 bit differs, so step stays at 1
    put(50);
    chk("R6 step min", $signed(est), 1);
    put(50);
    chk("R6 last bit cleared", $signed(est), 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule